// File: doc/BRIEF.md
# Trap privilege delegation unit

This block decides which privilege level takes a synchronous exception. A request carries a 4-bit cause code and the privilege level that was running when the exception was raised. Two 16-bit delegation registers each hold one bit per cause. The machine-owned register hands causes down to supervisor. The supervisor-owned register hands causes further down to user. Two enable inputs say whether supervisor mode and user-level trap handling exist at all.

The delegation choice is made in priority order. User comes first, then supervisor, and machine is the fallback. The result is then raised if needed, so that a trap never ends at a privilege below the one that was running. The answer is registered. A valid pulse comes out one cycle after each request, and the privilege output keeps its value until the next request arrives. Each register has a plain write strobe with data and a read-back output.

Top module: `trap_deleg_unit`

## Requirements
- R1: After reset, both delegation registers read 0, `rsp_valid_o` is 0 and `rsp_priv_o` is 2'b11 (machine).
- R2: When `n_ext_en_i` is 1 and bit `req_cause_i` of the supervisor-owned register is set, the chosen target is user (2'b00). This rule wins over every other rule.
- R3: When R2 does not apply, `s_ext_en_i` is 1 and bit `req_cause_i` of the machine-owned register is set, the chosen target is supervisor (2'b01).
- R4: When neither R2 nor R3 applies, the target is machine (2'b11). This includes the case where a register bit is set but its enable input is 0.
- R5: When the chosen target encoding is below the current privilege, compared unsigned, the result is the current privilege instead.
- R6: A current privilege of 2'b10 is handled as machine (2'b11), so the result for such a request is 2'b11.
- R7: Bits 10 and 14 of both registers always read 0 and ignore writes. Causes 10 and 14 therefore always go to machine.
- R8: `rsp_valid_o` is 1 exactly in the cycle after a cycle with `req_valid_i` set. `rsp_priv_o` changes only in that cycle and holds its value otherwise.
- R9: A register write in the same cycle as a request does not affect that request. It applies from the next cycle.
- R10: A write stores the written data, minus the bits named in R7, and read-back shows it in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdlg_we_i | input | 1 | Write strobe, machine-owned delegation register |
| mdlg_wdata_i | input | 16 | Write data, machine-owned register |
| mdlg_rdata_o | output | 16 | Read-back, machine-owned register |
| sdlg_we_i | input | 1 | Write strobe, supervisor-owned delegation register |
| sdlg_wdata_i | input | 16 | Write data, supervisor-owned register |
| sdlg_rdata_o | output | 16 | Read-back, supervisor-owned register |
| s_ext_en_i | input | 1 | Supervisor mode present |
| n_ext_en_i | input | 1 | User-level trap handling present |
| req_valid_i | input | 1 | Exception request strobe |
| req_cause_i | input | 4 | Exception cause code |
| req_priv_i | input | 2 | Privilege at which the exception occurred |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_priv_o | output | 2 | Privilege that handles the trap |

## Verification
The bench sets the same cause bit in both registers and then turns the enables off one at a time. A design with the priority reversed would give supervisor where user is expected. A design that ignores the enables would delegate when it should not. The bench sends delegated causes from higher privileges and from the 2'b10 encoding. A design without the clamp would return a lower privilege, and a missing normalisation would return 2'b10. It also writes all ones to hit the reserved bits, writes a register in the same cycle as a request, and idles after a result. These catch stored reserved bits, a decode that sees the new write too early, and an output that does not hold.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;
  localparam int unsigned NUM_CAUSE = 16;
  localparam int unsigned CAUSE_W   = $clog2(NUM_CAUSE);
  localparam int unsigned PRIV_W    = 2;
  // causes 10 and 14 are reserved
  localparam logic [NUM_CAUSE-1:0] RSVD_MASK = 16'h4400;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;
endpackage

// File: rtl/deleg_reg.sv
module deleg_reg #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] FIXED_ZERO = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & ~FIXED_ZERO;
  end

  assign rdata_o = q;

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/deleg_select.sv
module deleg_select
  import trap_deleg_pkg::*;
(
  input  logic [CAUSE_W-1:0]   cause_i,
  input  logic [PRIV_W-1:0]    cur_priv_i,
  input  logic [NUM_CAUSE-1:0] mdlg_i,
  input  logic [NUM_CAUSE-1:0] sdlg_i,
  input  logic                 s_ext_en_i,
  input  logic                 n_ext_en_i,
  output logic [PRIV_W-1:0]    tgt_priv_o
);
  logic [PRIV_W-1:0] cur_norm;
  logic [PRIV_W-1:0] pick;

  // 2'b10 is not a legal level; fold it into machine
  assign cur_norm = (cur_priv_i == 2'b10) ? PRIV_M : cur_priv_i;

  always_comb begin
    if (n_ext_en_i && sdlg_i[cause_i])      pick = PRIV_U;
    else if (s_ext_en_i && mdlg_i[cause_i]) pick = PRIV_S;
    else                                    pick = PRIV_M;
  end

  assign tgt_priv_o = (pick < cur_norm) ? cur_norm : pick;
endmodule

// File: rtl/trap_deleg_unit.sv
module trap_deleg_unit
  import trap_deleg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mdlg_we_i,
  input  logic [NUM_CAUSE-1:0] mdlg_wdata_i,
  output logic [NUM_CAUSE-1:0] mdlg_rdata_o,
  input  logic                 sdlg_we_i,
  input  logic [NUM_CAUSE-1:0] sdlg_wdata_i,
  output logic [NUM_CAUSE-1:0] sdlg_rdata_o,
  input  logic                 s_ext_en_i,
  input  logic                 n_ext_en_i,
  input  logic                 req_valid_i,
  input  logic [CAUSE_W-1:0]   req_cause_i,
  input  logic [PRIV_W-1:0]    req_priv_i,
  output logic                 rsp_valid_o,
  output logic [PRIV_W-1:0]    rsp_priv_o
);
  logic [PRIV_W-1:0] tgt_priv;

  deleg_reg #(.WIDTH(NUM_CAUSE), .FIXED_ZERO(RSVD_MASK)) i_mdlg (
    .clk_i, .rst_ni, .we_i(mdlg_we_i), .wdata_i(mdlg_wdata_i), .rdata_o(mdlg_rdata_o));

  deleg_reg #(.WIDTH(NUM_CAUSE), .FIXED_ZERO(RSVD_MASK)) i_sdlg (
    .clk_i, .rst_ni, .we_i(sdlg_we_i), .wdata_i(sdlg_wdata_i), .rdata_o(sdlg_rdata_o));

  deleg_select i_sel (
    .cause_i(req_cause_i), .cur_priv_i(req_priv_i),
    .mdlg_i(mdlg_rdata_o), .sdlg_i(sdlg_rdata_o),
    .s_ext_en_i, .n_ext_en_i, .tgt_priv_o(tgt_priv));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_priv_o  <= PRIV_M;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) rsp_priv_o <= tgt_priv;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_PRIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(rsp_priv_o) && !rsp_valid_o); // R8
  AST_NO_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_priv_o >= $past(req_priv_i)); // R5
  AST_LEGAL_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_priv_o != 2'b10); // R6
  AST_USER_NEEDS_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_priv_o == PRIV_U |-> $past(n_ext_en_i)); // R2
  AST_SUPER_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_priv_o == PRIV_S |-> $past(s_ext_en_i) || $past(req_priv_i) == PRIV_S); // R3
endmodule

// File: tb/test_trap_deleg_unit.sv
module test_trap_deleg_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mdlg_we_i = 1'b0, sdlg_we_i = 1'b0;
  logic [15:0] mdlg_wdata_i = '0, sdlg_wdata_i = '0;
  logic [15:0] mdlg_rdata_o, sdlg_rdata_o;
  logic        s_ext_en_i = 1'b0, n_ext_en_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_cause_i = '0;
  logic [1:0]  req_priv_i = '0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_priv_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  trap_deleg_unit i_trap_deleg_unit (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic m, logic [15:0] d);
    @(negedge clk_i);
    if (m) begin mdlg_we_i = 1'b1; mdlg_wdata_i = d; end
    else   begin sdlg_we_i = 1'b1; sdlg_wdata_i = d; end
    @(negedge clk_i);
    mdlg_we_i = 1'b0; sdlg_we_i = 1'b0;
  endtask

  task automatic req(string tag, logic [3:0] c, logic [1:0] p, logic [1:0] exp);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_cause_i = c; req_priv_i = p;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid_o), 32'd1);
    chk(tag, 32'(rsp_priv_o), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R1 valid", 32'(rsp_valid_o), 0);
    chk("R1 priv", 32'(rsp_priv_o), 32'h3);
    chk("R1 mreg", 32'(mdlg_rdata_o), 0);
    chk("R1 sreg", 32'(sdlg_rdata_o), 0);
    s_ext_en_i = 1'b1; n_ext_en_i = 1'b1;
    req("R1 R4 undelegated", 4'd2, 2'b00, 2'b11);
  endtask

  task automatic t_cascade;
    wr(1'b0, 16'h0008); wr(1'b1, 16'h0008);
    chk("R10 sreg", 32'(sdlg_rdata_o), 32'h0008);
    chk("R10 mreg", 32'(mdlg_rdata_o), 32'h0008);
    req("R2 user wins", 4'd3, 2'b00, 2'b00);
    n_ext_en_i = 1'b0;
    req("R3 super", 4'd3, 2'b00, 2'b01);
    s_ext_en_i = 1'b0;
    req("R4 both off", 4'd3, 2'b00, 2'b11);
    s_ext_en_i = 1'b1; n_ext_en_i = 1'b1;
    req("R4 other cause", 4'd5, 2'b00, 2'b11);
  endtask

  task automatic t_clamp;
    wr(1'b1, 16'h2008);
    req("R3 cause13 from U", 4'd13, 2'b00, 2'b01);
    req("R5 cause13 from S", 4'd13, 2'b01, 2'b01);
    req("R5 cause13 from M", 4'd13, 2'b11, 2'b11);
    req("R5 user tgt from S", 4'd3, 2'b01, 2'b01);
    req("R6 priv 10", 4'd3, 2'b10, 2'b11);
  endtask

  task automatic t_rsvd;
    wr(1'b1, 16'hFFFF); wr(1'b0, 16'hFFFF);
    chk("R7 mreg", 32'(mdlg_rdata_o), 32'hBBFF);
    chk("R7 sreg", 32'(sdlg_rdata_o), 32'hBBFF);
    req("R7 cause10", 4'd10, 2'b00, 2'b11);
    req("R7 cause14", 4'd14, 2'b00, 2'b11);
    req("R2 cause15", 4'd15, 2'b00, 2'b00);
  endtask

  task automatic t_hold;
    req("R8 setup", 4'd1, 2'b00, 2'b00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R8 idle valid", 32'(rsp_valid_o), 0);
      chk("R8 held priv", 32'(rsp_priv_o), 0);
    end
  endtask

  task automatic t_same_cycle;
    wr(1'b1, 16'h0000); wr(1'b0, 16'h0000);
    n_ext_en_i = 1'b0;
    @(negedge clk_i);
    mdlg_we_i = 1'b1; mdlg_wdata_i = 16'hFFFF;
    req_valid_i = 1'b1; req_cause_i = 4'd4; req_priv_i = 2'b00;
    @(negedge clk_i);
    mdlg_we_i = 1'b0; req_valid_i = 1'b0;
    chk("R9 old value", 32'(rsp_priv_o), 32'h3);
    req("R9 new value", 4'd4, 2'b00, 2'b01);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cascade();
    t_clamp();
    t_rsvd();
    t_hold();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule